// File: doc/BRIEF.md
# Transaction Checkpoint and Abort Controller

This block sits beside a small in-order core and holds that core's architectural register file. It carries out the three instructions that frame a hardware transaction: begin, end and explicit abort. An outermost begin copies every register into a checkpoint bank in one cycle and stores the fallback address that travels with the instruction. Begins issued inside a running transaction only deepen a nesting counter. Ends unwind the counter. The end that brings it back to zero tells the cache to make the speculative writes visible.

An abort can come from an explicit abort instruction, from a conflict reported by the cache, or from a begin that would push the nesting counter past its limit. Once an abort is accepted, the block raises `busy` to stall the core. It then copies the checkpoint back into the live registers a few registers per cycle. In its last busy cycle it writes a status word into one designated register and asks the core to jump to the fallback address. The core reads registers through two combinational read ports and writes through one write port.

Top module: `tx_ckpt_top`

## Requirements
- R1: After reset all registers read zero, `busy`, `pcRedirect`, `cacheCommit` and `cacheRollback` are low, and `txDepth` is zero.
- R2: A core write with `rfWrEn` high updates the addressed register at the clock edge, and the new value is visible on the read ports right after that edge. A core write, begin, end or abort presented while `busy` is high has no effect.
- R3: A begin at depth zero copies every register into the checkpoint, stores `txBeginPc` and sets the depth to one. A core write in the same cycle reaches the live register but not the checkpoint.
- R4: A begin at nonzero depth below the maximum adds one to the depth. It neither refreshes the checkpoint nor changes the stored fallback address.
- R5: An end at nonzero depth subtracts one from the depth. `cacheCommit` is a one-cycle pulse in the cycle after an end that takes the depth from one to zero, and it does not pulse for any other end.
- R6: An end, explicit abort or cache conflict received at depth zero is ignored. Depth, registers and all outputs stay as they were.
- R7: An accepted abort sets the depth to zero. `busy` is then high for exactly NREGS/LANES+1 consecutive cycles, starting in the cycle after acceptance. `cacheRollback` pulses in the first of those cycles.
- R8: `pcRedirect` is high in exactly one cycle, the last busy cycle. In that cycle `pcTarget` equals the fallback address of the outermost begin.
- R9: Once `busy` falls after an abort, every register other than the status register holds the value it had when the outermost begin was taken.
- R10: Once `busy` falls after an abort, the status register (index STATUS_IDX) holds the cause code in bits CODE_W-1:0 and a nested flag in bit CODE_W, with zeros above. The nested flag is set when the depth was two or more at acceptance. The cause code is `txAbortCode` for an explicit abort and `conflictCode` for a conflict.
- R11: When a cache conflict arrives in the same cycle as an instruction, the conflict wins. The instruction is dropped and the cause code comes from `conflictCode`.
- R12: A begin at the maximum depth (2^DEPTH_W-1) is turned into an abort with the all-ones cause code and the nested flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rfWrEn | input | 1 | Core register write enable |
| rfWrAddr | input | $clog2(NREGS) | Core write register index |
| rfWrData | input | DATA_W | Core write data |
| rdAddrA | input | $clog2(NREGS) | Read port A index |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | $clog2(NREGS) | Read port B index |
| rdDataB | output | DATA_W | Read port B data |
| txBegin | input | 1 | Begin instruction strobe |
| txBeginPc | input | PC_W | Fallback address carried by begin |
| txEnd | input | 1 | End instruction strobe |
| txAbort | input | 1 | Explicit abort instruction strobe |
| txAbortCode | input | CODE_W | Cause code of an explicit abort |
| conflictAbort | input | 1 | Conflict abort from the cache |
| conflictCode | input | CODE_W | Cause code supplied by the cache |
| busy | output | 1 | Core stall while restore runs |
| pcRedirect | output | 1 | Redirect strobe to the core |
| pcTarget | output | PC_W | Redirect target (stored fallback address) |
| cacheCommit | output | 1 | Commit pulse to the cache |
| cacheRollback | output | 1 | Discard pulse to the cache |
| txDepth | output | DEPTH_W | Current nesting depth |

## Verification
On every cycle, the bound checker confirms how the strobes relate to one another. It checks that `pcRedirect` comes only inside a busy window and ends it. It checks that `busy` cannot fall before the redirect, that a rising `busy` brings the rollback pulse, that the depth reads zero while restoring, and that commit and busy never overlap. Those properties do not cover register contents. The bench's scenarios show the data side: checkpoint contents after random write traffic, the exact length of the busy window, the status word for each abort cause and nesting level, and whether stimulus was ignored at depth zero or during restore. They also cover conflict priority and counter overflow.

// File: rtl/tx_ckpt_pkg.sv
package tx_ckpt_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_RESTORE = 2'd1,
    ST_FINISH  = 2'd2
  } ctrlState_t;

  // strobes from control to datapath, one bit each
  typedef struct packed {
    logic takeSnapshot;
    logic latchFallback;
    logic restoreEn;
    logic writeStatus;
    logic coreWrOk;
  } dpStrobes_t;

endpackage

// File: rtl/tx_ckpt_ctrl.sv
module tx_ckpt_ctrl
  import tx_ckpt_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int DEPTH_W = 2,
  parameter int NPHASE  = 4,
  parameter int PH_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txBegin,
  input  logic               txEnd,
  input  logic               txAbort,
  input  logic [CODE_W-1:0]  txAbortCode,
  input  logic               conflictAbort,
  input  logic [CODE_W-1:0]  conflictCode,
  output dpStrobes_t         strobes,
  output logic [PH_W-1:0]    restorePhase,
  output logic [CODE_W:0]    statusWord,
  output logic               busy,
  output logic               pcRedirect,
  output logic               cacheCommit,
  output logic               cacheRollback,
  output logic [DEPTH_W-1:0] txDepth
);

  localparam logic [PH_W-1:0]    LAST_PHASE = PH_W'(NPHASE - 1);
  localparam logic [DEPTH_W-1:0] DEPTH_ONE  = DEPTH_W'(1);
  localparam logic [CODE_W-1:0]  OVF_CODE   = '1;

  ctrlState_t         stateQ;
  logic [PH_W-1:0]    phaseQ;
  logic [DEPTH_W-1:0] depthQ;
  logic [CODE_W-1:0]  causeQ;
  logic               nestedQ;
  logic               commitQ;

  logic               running;
  logic               active;
  logic               depthFull;
  logic               abortTake;
  logic               beginOuter;
  logic               beginInner;
  logic               endTake;
  logic [CODE_W-1:0]  causeNext;

  always_comb begin
    running    = (stateQ == ST_RUN);
    active     = (depthQ != '0);
    depthFull  = (depthQ == '1);
    abortTake  = running && active &&
                 (conflictAbort || txAbort || (txBegin && depthFull));
    beginOuter = running && !abortTake && txBegin && !active;
    beginInner = running && !abortTake && txBegin && active;
    endTake    = running && !abortTake && !txBegin && txEnd && active;
    if (conflictAbort)  causeNext = conflictCode;
    else if (txAbort)   causeNext = txAbortCode;
    else                causeNext = OVF_CODE;
  end

  always_comb begin
    strobes.takeSnapshot  = beginOuter;
    strobes.latchFallback = beginOuter;
    strobes.restoreEn     = (stateQ == ST_RESTORE);
    strobes.writeStatus   = (stateQ == ST_FINISH);
    strobes.coreWrOk      = running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_RUN;
      phaseQ  <= '0;
      depthQ  <= '0;
      causeQ  <= '0;
      nestedQ <= 1'b0;
      commitQ <= 1'b0;
    end else begin
      commitQ <= endTake && (depthQ == DEPTH_ONE);
      unique case (stateQ)
        ST_RUN: begin
          if (abortTake) begin
            stateQ  <= ST_RESTORE;
            phaseQ  <= '0;
            depthQ  <= '0;
            causeQ  <= causeNext;
            nestedQ <= (depthQ > DEPTH_ONE);
          end else if (beginOuter || beginInner) begin
            depthQ <= depthQ + DEPTH_ONE;
          end else if (endTake) begin
            depthQ <= depthQ - DEPTH_ONE;
          end
        end
        ST_RESTORE: begin
          if (phaseQ == LAST_PHASE) stateQ <= ST_FINISH;
          else                      phaseQ <= phaseQ + PH_W'(1);
        end
        ST_FINISH: stateQ <= ST_RUN;
        default:   stateQ <= ST_RUN;
      endcase
    end
  end

  assign restorePhase  = phaseQ;
  assign statusWord    = {nestedQ, causeQ};
  assign busy          = (stateQ != ST_RUN);
  assign pcRedirect    = (stateQ == ST_FINISH);
  assign cacheCommit   = commitQ;
  assign cacheRollback = (stateQ == ST_RESTORE) && (phaseQ == '0);
  assign txDepth       = depthQ;

endmodule

// File: rtl/tx_ckpt_datapath.sv
module tx_ckpt_datapath
  import tx_ckpt_pkg::*;
#(
  parameter int NREGS      = 8,
  parameter int DATA_W     = 16,
  parameter int PC_W       = 16,
  parameter int LANES      = 2,
  parameter int STATUS_IDX = 1,
  parameter int STAT_W     = 5,
  parameter int AIDX_W     = 3,
  parameter int PH_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [PH_W-1:0]   restorePhase,
  input  logic [STAT_W-1:0] statusWord,
  input  logic              rfWrEn,
  input  logic [AIDX_W-1:0] rfWrAddr,
  input  logic [DATA_W-1:0] rfWrData,
  input  logic [PC_W-1:0]   txBeginPc,
  input  logic [AIDX_W-1:0] rdAddrA,
  input  logic [AIDX_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [PC_W-1:0]   fallbackPc
);

  localparam int PAD_W = DATA_W - STAT_W;

  logic [DATA_W-1:0] liveQ [NREGS];
  logic [DATA_W-1:0] ckptQ [NREGS];
  logic [PC_W-1:0]   fallbackQ;
  logic [DATA_W-1:0] statusExt;

  assign statusExt = {{PAD_W{1'b0}}, statusWord};

  for (genvar g = 0; g < NREGS; g++) begin : gReg
    localparam int REG_PHASE = g / LANES;
    logic inPhase;
    logic coreHit;
    assign inPhase = strobes.restoreEn && (restorePhase == PH_W'(REG_PHASE));
    assign coreHit = strobes.coreWrOk && rfWrEn && (rfWrAddr == AIDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ[g] <= '0;
      end else if (strobes.writeStatus && (g == STATUS_IDX)) begin
        liveQ[g] <= statusExt;
      end else if (inPhase) begin
        liveQ[g] <= ckptQ[g];
      end else if (coreHit) begin
        liveQ[g] <= rfWrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                     ckptQ[g] <= '0;
      else if (strobes.takeSnapshot) ckptQ[g] <= liveQ[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      fallbackQ <= '0;
    else if (strobes.latchFallback) fallbackQ <= txBeginPc;
  end

  assign rdDataA    = liveQ[rdAddrA];
  assign rdDataB    = liveQ[rdAddrB];
  assign fallbackPc = fallbackQ;

endmodule

// File: rtl/tx_ckpt_top.sv
module tx_ckpt_top
  import tx_ckpt_pkg::*;
#(
  parameter int NREGS      = 8,
  parameter int DATA_W     = 16,
  parameter int PC_W       = 16,
  parameter int CODE_W     = 4,
  parameter int DEPTH_W    = 2,
  parameter int LANES      = 2,
  parameter int STATUS_IDX = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rfWrEn,
  input  logic [$clog2(NREGS)-1:0] rfWrAddr,
  input  logic [DATA_W-1:0]        rfWrData,
  input  logic [$clog2(NREGS)-1:0] rdAddrA,
  output logic [DATA_W-1:0]        rdDataA,
  input  logic [$clog2(NREGS)-1:0] rdAddrB,
  output logic [DATA_W-1:0]        rdDataB,
  input  logic                     txBegin,
  input  logic [PC_W-1:0]          txBeginPc,
  input  logic                     txEnd,
  input  logic                     txAbort,
  input  logic [CODE_W-1:0]        txAbortCode,
  input  logic                     conflictAbort,
  input  logic [CODE_W-1:0]        conflictCode,
  output logic                     busy,
  output logic                     pcRedirect,
  output logic [PC_W-1:0]          pcTarget,
  output logic                     cacheCommit,
  output logic                     cacheRollback,
  output logic [DEPTH_W-1:0]       txDepth
);

  localparam int AIDX_W = $clog2(NREGS);
  localparam int NPHASE = (NREGS + LANES - 1) / LANES;
  localparam int PH_W   = (NPHASE > 1) ? $clog2(NPHASE) : 1;
  localparam int STAT_W = CODE_W + 1;

  dpStrobes_t        strobes;
  logic [PH_W-1:0]   restorePhase;
  logic [STAT_W-1:0] statusWord;

  tx_ckpt_ctrl #(
    .CODE_W (CODE_W),
    .DEPTH_W(DEPTH_W),
    .NPHASE (NPHASE),
    .PH_W   (PH_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .txBegin      (txBegin),
    .txEnd        (txEnd),
    .txAbort      (txAbort),
    .txAbortCode  (txAbortCode),
    .conflictAbort(conflictAbort),
    .conflictCode (conflictCode),
    .strobes      (strobes),
    .restorePhase (restorePhase),
    .statusWord   (statusWord),
    .busy         (busy),
    .pcRedirect   (pcRedirect),
    .cacheCommit  (cacheCommit),
    .cacheRollback(cacheRollback),
    .txDepth      (txDepth)
  );

  tx_ckpt_datapath #(
    .NREGS     (NREGS),
    .DATA_W    (DATA_W),
    .PC_W      (PC_W),
    .LANES     (LANES),
    .STATUS_IDX(STATUS_IDX),
    .STAT_W    (STAT_W),
    .AIDX_W    (AIDX_W),
    .PH_W      (PH_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .restorePhase(restorePhase),
    .statusWord  (statusWord),
    .rfWrEn      (rfWrEn),
    .rfWrAddr    (rfWrAddr),
    .rfWrData    (rfWrData),
    .txBeginPc   (txBeginPc),
    .rdAddrA     (rdAddrA),
    .rdAddrB     (rdAddrB),
    .rdDataA     (rdDataA),
    .rdDataB     (rdDataB),
    .fallbackPc  (pcTarget)
  );

endmodule

// File: rtl/tx_ckpt_checker.sv
module tx_ckpt_checker #(
  parameter int DEPTH_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               pcRedirect,
  input logic               cacheCommit,
  input logic               cacheRollback,
  input logic [DEPTH_W-1:0] txDepth
);

  assert_redirect_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    pcRedirect |-> busy);

  assert_redirect_ends_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    pcRedirect |=> !busy);

  assert_busy_holds_until_redirect_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pcRedirect) |=> busy);

  assert_rollback_on_busy_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> cacheRollback);

  assert_rollback_only_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    cacheRollback |-> busy);

  assert_depth_zero_in_restore_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (txDepth == '0));

  assert_commit_outside_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    cacheCommit |-> (!busy && txDepth == '0));

endmodule

bind tx_ckpt_top tx_ckpt_checker #(.DEPTH_W(DEPTH_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .busy         (busy),
  .pcRedirect   (pcRedirect),
  .cacheCommit  (cacheCommit),
  .cacheRollback(cacheRollback),
  .txDepth      (txDepth)
);

// File: tb/tx_ckpt_top_tb.sv
module tx_ckpt_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 8;
  localparam int DATA_W     = 16;
  localparam int PC_W       = 16;
  localparam int CODE_W     = 4;
  localparam int DEPTH_W    = 2;
  localparam int LANES      = 2;
  localparam int STATUS_IDX = 1;
  localparam int AIDX_W     = $clog2(NREGS);
  localparam int BUSY_CYC   = NREGS / LANES + 1;
  localparam int MAX_DEPTH  = (1 << DEPTH_W) - 1;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rfWrEn;
  logic [AIDX_W-1:0] rfWrAddr;
  logic [DATA_W-1:0] rfWrData;
  logic [AIDX_W-1:0] rdAddrA;
  logic [DATA_W-1:0] rdDataA;
  logic [AIDX_W-1:0] rdAddrB;
  logic [DATA_W-1:0] rdDataB;
  logic              txBegin;
  logic [PC_W-1:0]   txBeginPc;
  logic              txEnd;
  logic              txAbort;
  logic [CODE_W-1:0] txAbortCode;
  logic              conflictAbort;
  logic [CODE_W-1:0] conflictCode;
  logic              busy;
  logic              pcRedirect;
  logic [PC_W-1:0]   pcTarget;
  logic              cacheCommit;
  logic              cacheRollback;
  logic [DEPTH_W-1:0] txDepth;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx_ckpt_top #(
    .NREGS(NREGS), .DATA_W(DATA_W), .PC_W(PC_W), .CODE_W(CODE_W),
    .DEPTH_W(DEPTH_W), .LANES(LANES), .STATUS_IDX(STATUS_IDX)
  ) dut_i (
    .clk(clk), .rstN(rstN), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .txBegin(txBegin), .txBeginPc(txBeginPc), .txEnd(txEnd), .txAbort(txAbort),
    .txAbortCode(txAbortCode), .conflictAbort(conflictAbort), .conflictCode(conflictCode),
    .busy(busy), .pcRedirect(pcRedirect), .pcTarget(pcTarget), .cacheCommit(cacheCommit),
    .cacheRollback(cacheRollback), .txDepth(txDepth)
  );

  int vectors = 0;
  int errors  = 0;
  logic [DATA_W-1:0] refLive [NREGS];
  logic [DATA_W-1:0] refCkpt [NREGS];
  int                refDepth;
  logic [PC_W-1:0]   refPc;

  function automatic logic [DATA_W-1:0] statusOf(input logic nested, input logic [CODE_W-1:0] code);
    return DATA_W'({nested, code});
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearIns();
    rfWrEn = 0; rfWrAddr = '0; rfWrData = '0;
    txBegin = 0; txBeginPc = '0; txEnd = 0; txAbort = 0; txAbortCode = '0;
    conflictAbort = 0; conflictCode = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkRegs(input string reqMain, input bit afterAbort);
    for (int i = 0; i < NREGS; i++) begin
      rdAddrA = AIDX_W'(i);
      rdAddrB = AIDX_W'((i + 3) % NREGS);
      #1;
      if (afterAbort && i == STATUS_IDX) chk("R10 status reg", rdDataA, refLive[i]);
      else                               chk(reqMain, rdDataA, refLive[i]);
      chk(reqMain, rdDataB, refLive[(i + 3) % NREGS]);
    end
  endtask

  // abort sequence: kind 0 explicit, 1 conflict (optionally with a competing end), 2 overflow begin
  task automatic doAbort(input int kind, input logic [CODE_W-1:0] code, input bit withInstr);
    int busyCnt;
    int redirCnt;
    logic nested;
    logic [CODE_W-1:0] expCode;
    nested = (refDepth > 1);
    clearIns();
    if (kind == 0) begin
      txAbort = 1; txAbortCode = code; expCode = code;
    end else if (kind == 1) begin
      conflictAbort = 1; conflictCode = code; expCode = code;
      if (withInstr) begin txEnd = 1; txAbort = 1; txAbortCode = ~code; end
    end else begin
      txBegin = 1; txBeginPc = 16'hDEAD; expCode = '1;
    end
    tick();
    clearIns();
    for (int i = 0; i < NREGS; i++) refLive[i] = refCkpt[i];
    refLive[STATUS_IDX] = statusOf(nested, expCode);
    refDepth = 0;
    chk("R7 rollback pulse first busy cycle", {31'd0, cacheRollback}, 32'd1);
    busyCnt = 0;
    redirCnt = 0;
    for (int g = 0; g < 20 && busy; g++) begin
      busyCnt++;
      if (pcRedirect) begin
        redirCnt++;
        chk("R8 redirect in last busy cycle", busyCnt, BUSY_CYC);
        chk("R8 redirect target", {16'd0, pcTarget}, {16'd0, refPc});
      end
      if (g == 0) begin
        // ignored stimulus while busy (R2)
        rfWrEn = 1; rfWrAddr = AIDX_W'(0); rfWrData = 16'hFFFF;
        txBegin = 1; txBeginPc = 16'h1111; txEnd = 1;
      end
      tick();
      clearIns();
    end
    chk("R7 busy length", busyCnt, BUSY_CYC);
    chk("R8 single redirect", redirCnt, 1);
    chk("R7 depth zero after abort", {30'd0, txDepth}, 32'd0);
    checkRegs("R9 restored reg (R2 busy write ignored)", 1'b1);
  endtask

  task automatic doWrite(input int a, input logic [DATA_W-1:0] d);
    clearIns();
    rfWrEn = 1; rfWrAddr = AIDX_W'(a); rfWrData = d;
    tick();
    clearIns();
    refLive[a] = d;
    rdAddrA = AIDX_W'(a); rdAddrB = AIDX_W'((a + 1) % NREGS);
    #1;
    chk("R2 write visible", rdDataA, d);
    chk("R2 other reg", rdDataB, refLive[(a + 1) % NREGS]);
  endtask

  task automatic doBegin(input logic [PC_W-1:0] pc, input bit alsoWrite, input int a, input logic [DATA_W-1:0] d);
    clearIns();
    txBegin = 1; txBeginPc = pc;
    if (alsoWrite) begin rfWrEn = 1; rfWrAddr = AIDX_W'(a); rfWrData = d; end
    tick();
    clearIns();
    if (refDepth == 0) begin
      for (int i = 0; i < NREGS; i++) refCkpt[i] = refLive[i];
      refPc = pc;
    end
    if (alsoWrite) refLive[a] = d;
    refDepth++;
    chk(refDepth == 1 ? "R3 depth after outer begin" : "R4 depth after nested begin",
        {30'd0, txDepth}, refDepth);
    chk("R3 no busy on begin", {31'd0, busy}, 32'd0);
  endtask

  task automatic doEnd();
    bit expCommit;
    clearIns();
    txEnd = 1;
    tick();
    clearIns();
    expCommit = (refDepth == 1);
    if (refDepth > 0) refDepth--;
    chk(refDepth == 0 && !expCommit ? "R6 end outside ignored" : "R5 depth after end",
        {30'd0, txDepth}, refDepth);
    chk("R5 commit pulse", {31'd0, cacheCommit}, {31'd0, expCommit});
    if (expCommit) begin
      tick();
      chk("R5 commit one cycle", {31'd0, cacheCommit}, 32'd0);
    end
  endtask

  task automatic doIgnoredAbort(input bit conflict);
    clearIns();
    if (conflict) begin conflictAbort = 1; conflictCode = 4'h5; end
    else begin txAbort = 1; txAbortCode = 4'h6; end
    tick();
    clearIns();
    chk("R6 abort outside ignored busy", {31'd0, busy}, 32'd0);
    chk("R6 abort outside ignored depth", {30'd0, txDepth}, 32'd0);
    checkRegs("R6 regs unchanged", 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clearIns();
    rdAddrA = '0; rdAddrB = '0;
    rstN = 0;
    for (int i = 0; i < NREGS; i++) begin refLive[i] = '0; refCkpt[i] = '0; end
    refDepth = 0; refPc = '0;
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 redirect", {31'd0, pcRedirect}, 32'd0);
    chk("R1 commit", {31'd0, cacheCommit}, 32'd0);
    chk("R1 rollback", {31'd0, cacheRollback}, 32'd0);
    chk("R1 depth", {30'd0, txDepth}, 32'd0);
    checkRegs("R1 reg zero", 1'b0);

    // directed: fill registers
    for (int i = 0; i < NREGS; i++) doWrite(i, DATA_W'(16'h100 + i * 7));
    // R6 outside-transaction stimulus
    doEnd();
    doIgnoredAbort(1'b0);
    doIgnoredAbort(1'b1);
    // R3 snapshot with same-cycle write, R4 nesting, R12 overflow
    doBegin(16'h4000, 1'b1, 2, 16'hABCD);
    doWrite(5, 16'h5555);
    doBegin(16'h4100, 1'b0, 0, '0);
    doBegin(16'h4200, 1'b0, 0, '0);
    chk("R12 depth at max", {30'd0, txDepth}, MAX_DEPTH);
    doAbort(2, '0, 1'b0);
    // flat explicit abort, nested flag clear
    doBegin(16'h2222, 1'b0, 0, '0);
    doWrite(3, 16'h3333);
    doAbort(0, 4'h9, 1'b0);
    // R11 conflict versus competing instructions, nested
    doBegin(16'h7000, 1'b0, 0, '0);
    doBegin(16'h7100, 1'b0, 0, '0);
    doWrite(7, 16'h7777);
    doAbort(1, 4'h3, 1'b1);
    // commit path
    doBegin(16'h0A00, 1'b0, 0, '0);
    doBegin(16'h0B00, 1'b0, 0, '0);
    doEnd();
    doEnd();
    checkRegs("R5 regs kept after commit", 1'b0);

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 7) begin
        doWrite(int'($urandom % NREGS), DATA_W'($urandom));
      end else if (r < 10) begin
        if (refDepth == MAX_DEPTH) doAbort(2, '0, 1'b0);
        else doBegin(PC_W'($urandom), ($urandom % 2) == 1, int'($urandom % NREGS), DATA_W'($urandom));
      end else if (r < 13) begin
        doEnd();
      end else if (r == 13) begin
        if (refDepth == 0) doIgnoredAbort(1'b0);
        else doAbort(0, CODE_W'($urandom), 1'b0);
      end else begin
        if (refDepth == 0) doIgnoredAbort(1'b1);
        else doAbort(1, CODE_W'($urandom), r == 15);
      end
    end
    checkRegs("R2 final register image", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule